// File: doc/BRIEF.md
# Backlog-Ordered Broadcast Scheduler

This block lives in a message engine that shares one local bus among four processing nodes. A broadcast request names a source node and a word count. When the request is accepted, the scheduler takes a snapshot of every node's remaining earlier transmit backlog. A fixed four-input sorting network then turns that snapshot into a destination order. Nodes that will drain soonest come first. The source node always goes last and is never served.

Broadcast words enter from a single stream. They then move through a three-stage pipeline, one stage per destination slot, so that word k reaches the second destination one advance after it reaches the first. A stage holds its word until the live backlog of its destination node is zero. Any waiting stage freezes the whole pipeline, so the wait for a busy node overlaps the delivery of words to nodes that are already free. A one-cycle done pulse closes each broadcast. Only after that can a new request be acknowledged.

Top module: `bcast_sched`

## Requirements
- R1: After reset, with req_i low, ack_o, din_ready_o, done_o and every bit of node_valid_o are low.
- R2: While idle, ack_o follows req_i in the same cycle. The clock edge at which ack_o is high accepts the request and latches src_i, len_i and all four backlog_i fields.
- R3: From acceptance until done_o, ack_o stays low even if req_i is held high. Each broadcast produces exactly one ack cycle.
- R4: Destinations are served in ascending order of their latched backlog. Equal backlogs go to the lower node index first. Later changes on backlog_i do not alter the order.
- R5: The source node receives no word: its node_valid_o bit stays low for the whole broadcast.
- R6: node_valid_o[n] is high only in a cycle where backlog field n (bits n*CNT_W upward) is zero. While any loaded stage waits on a busy node, the whole pipeline holds.
- R7: Every destination receives all len words in stream order. With all destinations free and no gaps in the input, slot s first receives s cycles after slot 0, and the last delivery comes len+1 cycles after the first.
- R8: The order takes a fixed two cycles to form. No word is delivered in the two cycles after the ack cycle, and with free destinations the first delivery falls exactly three cycles after it.
- R9: din_ready_o is high only while a broadcast is active, fewer than len words have been taken, and the pipeline advances. Exactly len words are consumed per broadcast.
- R10: done_o is high for exactly one cycle, the cycle after the final delivery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Broadcast request, held until ack_o |
| src_i | input | 2 | Source node index |
| len_i | input | LEN_W | Words in the broadcast |
| ack_o | output | 1 | Request accepted this cycle |
| backlog_i | input | 4*CNT_W | Remaining earlier transmit words, field n for node n |
| din_valid_i | input | 1 | Broadcast word available |
| din_data_i | input | DATA_W | Broadcast word |
| din_ready_o | output | 1 | Word taken this cycle |
| node_valid_o | output | 4 | Word delivered to node n this cycle |
| node_data_o | output | 4*DATA_W | Per-node word, field n for node n |
| done_o | output | 1 | Broadcast complete pulse |

## Verification
Several properties are checked on every cycle by assertions. A node is never served while its live backlog is nonzero, and the source is never served. The latched order is always strictly ascending by backlog and index. There are no deliveries in the two cycles after an ack, acks and done pulses never repeat back to back, and the pipeline freezes while any stage waits. Other behaviours can only be shown by the bench's scenarios: that the order matches an independently computed sort for the given backlogs and ties, that every word arrives intact and in sequence at each destination, the exact skew and span of the pipeline, input gaps, the number of words consumed, and where the done pulse falls relative to the last delivery.

// File: rtl/bcast_pkg.sv
package bcast_pkg;
  localparam int NODES  = 4;
  localparam int NODE_W = 2;
  localparam int NDST   = NODES - 1;

  typedef logic [NODE_W-1:0] node_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SORT,
    ST_RUN
  } state_e;
endpackage

// File: rtl/bcast_sort.sv
module bcast_sort
  import bcast_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic [NODES*CNT_W-1:0] cnt_i,
  input  node_t                  src_i,
  output node_t [NODES-1:0]      ord_o
);
  // key = {is_source, backlog, index}: unique, so the network needs no stability
  localparam int KW = 1 + CNT_W + NODE_W;
  typedef logic [KW-1:0] key_t;

  function automatic key_t kmin(key_t a, key_t b);
    return (a < b) ? a : b;
  endfunction

  function automatic key_t kmax(key_t a, key_t b);
    return (a < b) ? b : a;
  endfunction

  key_t l0 [NODES];
  key_t l1 [NODES];
  key_t l2 [NODES];
  key_t l3 [NODES];

  always_comb begin
    for (int n = 0; n < NODES; n++)
      l0[n] = {node_t'(n) == src_i, cnt_i[n*CNT_W +: CNT_W], node_t'(n)};
    l1[0] = kmin(l0[0], l0[1]);
    l1[1] = kmax(l0[0], l0[1]);
    l1[2] = kmin(l0[2], l0[3]);
    l1[3] = kmax(l0[2], l0[3]);
    l2[0] = kmin(l1[0], l1[2]);
    l2[2] = kmax(l1[0], l1[2]);
    l2[1] = kmin(l1[1], l1[3]);
    l2[3] = kmax(l1[1], l1[3]);
    l3[0] = l2[0];
    l3[1] = kmin(l2[1], l2[2]);
    l3[2] = kmax(l2[1], l2[2]);
    l3[3] = l2[3];
    for (int n = 0; n < NODES; n++)
      ord_o[n] = l3[n][NODE_W-1:0];
  end
endmodule

// File: rtl/bcast_pipe.sv
module bcast_pipe
  import bcast_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  node_t [NDST-1:0]        dest_i,
  input  logic [NODES-1:0]        free_i,
  input  logic                    push_i,
  input  logic [DATA_W-1:0]       data_i,
  output logic                    fire_o,
  output logic [NDST-1:0]         occ_o,
  output logic [NODES-1:0]        node_valid_o,
  output logic [NODES*DATA_W-1:0] node_data_o
);
  logic [NDST-1:0]   v_q;
  logic [NDST-1:0]   ok;
  logic [DATA_W-1:0] d_q [NDST];

  genvar s;
  generate
    for (s = 0; s < NDST; s++) begin : g_stage
      assign ok[s] = !v_q[s] || free_i[dest_i[s]];
      if (s == 0) begin : g_head
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) begin
            v_q[s] <= 1'b0;
            d_q[s] <= '0;
          end else if (fire_o) begin
            v_q[s] <= push_i;
            d_q[s] <= data_i;
          end
        end
      end else begin : g_body
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) begin
            v_q[s] <= 1'b0;
            d_q[s] <= '0;
          end else if (fire_o) begin
            v_q[s] <= v_q[s-1];
            d_q[s] <= d_q[s-1];
          end
        end
      end

      a_r6_hold_on_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (v_q[s] && !free_i[dest_i[s]]) |=> $stable(v_q))
        else $error("pipeline moved while a stage waited");
    end
  endgenerate

  assign fire_o = &ok;
  assign occ_o  = v_q;

  always_comb begin
    node_valid_o = '0;
    node_data_o  = '0;
    for (int n = 0; n < NODES; n++)
      for (int k = 0; k < NDST; k++)
        if (v_q[k] && dest_i[k] == node_t'(n)) begin
          node_valid_o[n]                  = fire_o;
          node_data_o[n*DATA_W +: DATA_W]  = d_q[k];
        end
  end

  a_r9_push_only_on_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> fire_o)
    else $error("word pushed into a held pipeline");
endmodule

// File: rtl/bcast_sched.sv
module bcast_sched
  import bcast_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8,
  parameter int LEN_W  = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_i,
  input  logic [NODE_W-1:0]       src_i,
  input  logic [LEN_W-1:0]        len_i,
  output logic                    ack_o,
  input  logic [NODES*CNT_W-1:0]  backlog_i,
  input  logic                    din_valid_i,
  input  logic [DATA_W-1:0]       din_data_i,
  output logic                    din_ready_o,
  output logic [NODES-1:0]        node_valid_o,
  output logic [NODES*DATA_W-1:0] node_data_o,
  output logic                    done_o
);
  state_e               state_q;
  logic [NODES*CNT_W-1:0] snap_q;
  node_t                src_q;
  logic [LEN_W-1:0]     len_q, in_cnt_q;
  node_t [NODES-1:0]    ord_d, ord_q;
  logic                 done_q;
  logic [NODES-1:0]     free;
  logic                 running, fire, more, take, last;
  logic [NDST-1:0]      occ;

  genvar n;
  generate
    for (n = 0; n < NODES; n++) begin : g_free
      assign free[n] = backlog_i[n*CNT_W +: CNT_W] == '0;
      a_r6_busy_node_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
        node_valid_o[n] |-> backlog_i[n*CNT_W +: CNT_W] == '0)
        else $error("word delivered to busy node");
    end
  endgenerate

  bcast_sort #(.CNT_W(CNT_W)) u_sort (
    .cnt_i (snap_q),
    .src_i (src_q),
    .ord_o (ord_d)
  );

  assign running = state_q == ST_RUN;
  assign more    = in_cnt_q != len_q;
  assign take    = running && more && din_valid_i && fire;
  // final advance: nothing left to take and only the last slot may still hold a word
  assign last    = running && fire && !more && !(|occ[NDST-2:0]);

  bcast_pipe #(.DATA_W(DATA_W)) u_pipe (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .dest_i       (ord_q[NDST-1:0]),
    .free_i       (free),
    .push_i       (take),
    .data_i       (din_data_i),
    .fire_o       (fire),
    .occ_o        (occ),
    .node_valid_o (node_valid_o),
    .node_data_o  (node_data_o)
  );

  assign ack_o       = state_q == ST_IDLE && req_i;
  assign din_ready_o = running && more && fire;
  assign done_o      = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      snap_q   <= '0;
      src_q    <= '0;
      len_q    <= '0;
      in_cnt_q <= '0;
      ord_q    <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= last;
      unique case (state_q)
        ST_IDLE: if (ack_o) begin
          snap_q   <= backlog_i;
          src_q    <= src_i;
          len_q    <= len_i;
          in_cnt_q <= '0;
          state_q  <= ST_SORT;
        end
        ST_SORT: begin
          ord_q   <= ord_d;
          state_q <= ST_RUN;
        end
        ST_RUN: begin
          if (take) in_cnt_q <= in_cnt_q + 1'b1;
          if (last) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  genvar s;
  generate
    for (s = 0; s + 1 < NDST; s++) begin : g_ord_chk
      a_r4_order_ascending: assert property (@(posedge clk_i) disable iff (!rst_ni)
        running |-> {snap_q[ord_q[s]*CNT_W +: CNT_W], ord_q[s]}
                  < {snap_q[ord_q[s+1]*CNT_W +: CNT_W], ord_q[s+1]})
        else $error("destination order not ascending");
    end
  endgenerate

  a_r5_source_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    running |-> ord_q[NODES-1] == src_q)
    else $error("source placed among destinations");
  a_r5_source_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != ST_IDLE |-> !node_valid_o[src_q])
    else $error("source node served");
  a_r3_single_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o)
    else $error("back-to-back ack");
  a_r8_no_early_data1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(ack_o) |-> node_valid_o == '0)
    else $error("delivery one cycle after ack");
  a_r8_no_early_data2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(ack_o, 2) |-> node_valid_o == '0)
    else $error("delivery two cycles after ack");
  a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o)
    else $error("done longer than one cycle");
  a_r10_done_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> node_valid_o == '0)
    else $error("delivery in done cycle");
  a_r9_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    running |-> in_cnt_q <= len_q)
    else $error("more words taken than requested");
endmodule

// File: tb/bcast_sched_test.sv
module bcast_sched_test;
  import bcast_pkg::*;
  localparam int DW = 16;
  localparam int CW = 8;
  localparam int LW = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req = 1'b0;
  logic [1:0]        src = '0;
  logic [LW-1:0]     len = '0;
  logic              ack;
  logic [NODES*CW-1:0] backlog;
  logic              din_valid = 1'b0;
  logic [DW-1:0]     din_data = '0;
  logic              din_ready;
  logic [NODES-1:0]  node_valid;
  logic [NODES*DW-1:0] node_data;
  logic              done;

  int errors = 0, checks = 0, cyc = 0, word = 0;
  int bl [NODES];
  bit took = 0, gappy = 0;
  logic [DW-1:0] expq [NODES][$];
  int first [NODES];
  int last_valid = 0, done_cnt = 0, done_cyc = 0, ack_cnt = 0, ack_cyc = 0;

  always #2 clk = ~clk;  // 250 MHz

  always_comb
    for (int n = 0; n < NODES; n++) backlog[n*CW +: CW] = CW'(bl[n]);

  bcast_sched #(.DATA_W(DW), .CNT_W(CW), .LEN_W(LW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .src_i(src), .len_i(len),
    .ack_o(ack), .backlog_i(backlog), .din_valid_i(din_valid),
    .din_data_i(din_data), .din_ready_o(din_ready),
    .node_valid_o(node_valid), .node_data_o(node_data), .done_o(done)
  );

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // node drain model and input stream driver
  initial begin
    for (int n = 0; n < NODES; n++) bl[n] = 0;
    forever begin
      @(posedge clk); #1;
      for (int n = 0; n < NODES; n++) if (bl[n] > 0) bl[n]--;
      if (took) word++;
      din_data  = DW'(16'hA000 + word);
      din_valid = !(gappy && (cyc % 3 == 0));
    end
  end

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk); #1;
      cyc++;
      took = din_ready && din_valid;
      if (rst_n) begin
        for (int n = 0; n < NODES; n++)
          if (node_valid[n]) begin
            chk("R6 node free when served", bl[n], 0);
            if (expq[n].size() == 0) chk("R5 unexpected delivery", 1, 0);
            else chk("R7 word value", int'(node_data[n*DW +: DW]), int'(expq[n].pop_front()));
            if (first[n] < 0) first[n] = cyc;
            last_valid = cyc;
          end
        if (done) begin done_cnt++; done_cyc = cyc; end
        if (ack) begin ack_cnt++; ack_cyc = cyc; end
      end
    end
  end

  task automatic run(int s, int n_len, int b0, int b1, int b2, int b3, bit gap, bit hold);
    int ord [NDST];
    int k, base, a0, d0, tmp;
    bit all_free;
    @(negedge clk);
    bl[0] = b0; bl[1] = b1; bl[2] = b2; bl[3] = b3;
    src = 2'(s); len = LW'(n_len); gappy = gap;
    for (int n = 0; n < NODES; n++) first[n] = -1;
    k = 0;
    for (int n = 0; n < NODES; n++) if (n != s) begin ord[k] = n; k++; end
    for (int i = 0; i < NDST; i++)
      for (int j = 0; j + 1 < NDST; j++)
        if (bl[ord[j]] > bl[ord[j+1]]) begin
          tmp = ord[j]; ord[j] = ord[j+1]; ord[j+1] = tmp;
        end
    all_free = !gap;
    for (int i = 0; i < NDST; i++) if (bl[ord[i]] != 0) all_free = 0;
    base = word;
    for (int n = 0; n < NODES; n++)
      if (n != s)
        for (int w = 0; w < n_len; w++) expq[n].push_back(DW'(16'hA000 + base + w));
    a0 = ack_cnt; d0 = done_cnt;
    req = 1'b1;
    wait (ack_cnt == a0 + 1);
    if (hold) repeat (4) @(negedge clk);
    else @(negedge clk);
    req = 1'b0;
    wait (done_cnt == d0 + 1);
    repeat (4) @(negedge clk);
    #2;
    chk("R3 one ack per broadcast", ack_cnt - a0, 1);
    chk("R10 single done pulse", done_cnt - d0, 1);
    chk("R10 done after last word", done_cyc, last_valid + 1);
    chk("R5 source not served", first[s], -1);
    for (int i = 0; i < NDST; i++) chk("R7 all words delivered", expq[ord[i]].size(), 0);
    for (int i = 1; i < NDST; i++)
      chk("R4 service order", int'(first[ord[i]] > first[ord[i-1]]), 1);
    chk("R8 no early delivery", int'(first[ord[0]] >= ack_cyc + 3), 1);
    chk("R9 words consumed", word - base, n_len);
    if (all_free) begin
      chk("R8 first delivery latency", first[ord[0]], ack_cyc + 3);
      for (int i = 1; i < NDST; i++) chk("R7 slot skew", first[ord[i]], first[ord[0]] + i);
      chk("R7 broadcast span", last_valid, first[ord[0]] + n_len + 1);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1 ack idle in reset", int'(ack), 0);
    chk("R1 ready idle in reset", int'(din_ready), 0);
    chk("R1 valid idle in reset", int'(node_valid), 0);
    chk("R1 done idle in reset", int'(done), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1 outputs idle after reset", int'({ack, din_ready, node_valid, done}), 0);
    @(negedge clk);
    req = 1'b1; #1;
    chk("R2 ack follows req when idle", int'(ack), 1);
    req = 1'b0;
    repeat (2) @(negedge clk);
    // R2 R7 R8: all free, plain pipeline timing
    run(0, 4, 0, 0, 0, 0, 0, 0);
    // R4 R6: distinct backlogs, stalls on the slowest node
    run(2, 5, 6, 2, 0, 9, 0, 0);
    // R4 ties broken by lower index
    run(3, 3, 5, 3, 3, 0, 0, 0);
    // R3 R9: request held during broadcast, gaps in input stream
    run(1, 6, 0, 0, 4, 0, 1, 1);
    // R7 boundary: single word, all free
    run(3, 1, 0, 0, 0, 0, 0, 0);
    // R4 R6: long stall on last slot
    run(0, 8, 0, 20, 1, 1, 0, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule